// File: doc/BRIEF.md
# Slow-Domain Register Write Bridge

This block accepts 32-bit register writes from a fast bus clock and applies them to a small register file that belongs to a slow, always-on domain running from a 32.768 kHz clock. The slow clock enters as a plain input. It is brought into the bus domain through a flop chain, and each of its rising edges becomes a one-cycle tick. Every slow-domain write is held in a single staging slot until a fixed number of ticks has passed. Only then is it applied, and the block reports completion through a status word.

Software sees four status flags: busy, ready-for-next, done and error. The done flag clears itself when the status word is read. A second slow-domain write that arrives while one is still being synchronised is thrown away and raises the error flag. The error flag is cleared by writing a one to its bit, and that clearing write is synchronised like any other. The interrupt-enable register is the exception. It is held in the bus domain, takes effect at once, and never touches the handshake. A single interrupt line reports a finished write when its enable bit is set.

Top module: `lpws_bridge`

## Requirements
- R1: After reset the status word reads 0x0000_0200 (busy bit 10 = 0, ready bit 9 = 1, done bit 8 = 0, error bit 7 = 0), the interrupt-enable word reads 0, and `irq_wc` is low.
- R2: A write to a data register (addresses 0 to NUM_REGS-1) or to the status word (address NUM_REGS), made while the block is idle, is accepted. From the next cycle the status word shows busy = 1 and ready = 0.
- R3: An accepted write is applied after exactly SYNC_TICKS rising edges of the slow clock. Before that, busy stays 1 and the target register still reads its old value. Afterwards it reads the new value.
- R4: When the write is applied, busy returns to 0, ready returns to 1 and done (bit 8) is set.
- R5: A read of the status word returns the done flag as it stood and then clears it. The next read returns done = 0.
- R6: A write to the interrupt-enable register (address NUM_REGS+1, bits 9, 8 and 7 kept) can be read back on the next access. It is allowed while busy, does not set busy, done or error, and does not disturb the pending write.
- R7: A slow-domain write issued while busy sets error (bit 7) from the next cycle and is discarded. The write already in flight completes with its own data.
- R8: Writing the status word with bit 7 = 1 clears error, but only when that write is applied. Until then error reads 1.
- R9: `irq_wc` is high while done and enable bit 8 are both set, with one cycle of register delay. It falls after a status read clears done or after enable bit 8 is cleared.
- R10: A status write with bit 7 = 0 leaves error unchanged and still completes with done set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_clk | input | 1 | Slow 32.768 kHz clock, asynchronous to `clk` |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; data appears on `rdata` the next cycle |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, one cycle after `rd_en` |
| irq_wc | output | 1 | Write-done interrupt request |

## Verification
The bench uses the default parameters: SYNC_TICKS = 4, eight data registers and a two-stage synchroniser. The slow clock runs at one sixteenth of the bus clock. With that ratio the test can count slow edges between the acceptance of a write and its completion, and can look at the status word while three edges have passed and one is still to come. It also lets a colliding second write, a bus-speed enable write and the synchronised error clear all fall inside one synchronisation window.

// File: rtl/lpws_pkg.sv
package lpws_pkg;
  localparam int BUSY_BIT = 10;
  localparam int NEXT_BIT = 9;
  localparam int DONE_BIT = 8;
  localparam int ERR_BIT  = 7;
  localparam int IEN_HI   = 9;
  localparam int IEN_LO   = 7;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_IEN  = 2'd2,
    SEL_NONE = 2'd3
  } rsel_e;
endpackage

// File: rtl/lpws_tick.sv
module lpws_tick #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lp_clk,
  output logic tick
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      tick <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-1:0], lp_clk};
      tick <= sh[STAGES-1] & ~sh[STAGES];
    end
  end

  // R3: one slow edge yields exactly one tick
  a_r3_single_tick: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/lpws_engine.sv
module lpws_engine #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int TICKS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              apply,
  output logic              collide,
  output logic [ADDR_W-1:0] ap_addr,
  output logic [DATA_W-1:0] ap_data
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  assign apply   = busy & tick & (cnt == LAST);
  assign collide = req & busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      ap_addr <= '0;
      ap_data <= '0;
    end else if (!busy && req) begin
      busy    <= 1'b1;
      cnt     <= '0;
      ap_addr <= req_addr;
      ap_data <= req_data;
    end else if (busy && tick) begin
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end

  // R2: a write is accepted only from a request
  a_r2_accept_on_req: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req));
  // R3: completion happens only on a slow tick
  a_r3_done_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(tick));
  // R7: staged data is frozen while a write is in flight
  a_r7_hold_data: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ap_data));
endmodule

// File: rtl/lpws_regfile.sv
module lpws_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lpws_status.sv
module lpws_status
  import lpws_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              apply,
  input  logic              ap_is_stat,
  input  logic              ap_err_clr,
  input  logic              collide,
  input  logic              stat_rd,
  input  logic              ien_we,
  input  logic [IEN_HI:IEN_LO] ien_wdata,
  output logic [DATA_W-1:0] stat_word,
  output logic [DATA_W-1:0] ien_word,
  output logic              irq
);
  logic done, err;
  logic [IEN_HI:IEN_LO] ien;

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      err  <= 1'b0;
      ien  <= '0;
      irq  <= 1'b0;
    end else begin
      if (apply)        done <= 1'b1;
      else if (stat_rd) done <= 1'b0;

      if (collide)                               err <= 1'b1;
      else if (apply && ap_is_stat && ap_err_clr) err <= 1'b0;

      if (ien_we) ien <= ien_wdata;

      irq <= done & ien[DONE_BIT];
    end
  end

  always_comb begin
    stat_word           = '0;
    stat_word[BUSY_BIT] = busy;
    stat_word[NEXT_BIT] = ~busy;
    stat_word[DONE_BIT] = done;
    stat_word[ERR_BIT]  = err;
    ien_word            = '0;
    ien_word[IEN_HI:IEN_LO] = ien;
  end

  // R4: done rises only when a write is applied
  a_r4_done_src: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(apply));
  // R7: error rises only on a colliding write
  a_r7_err_src: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(collide));
  // R8: error falls only when a clearing write is applied
  a_r8_err_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(err) |-> $past(apply && ap_is_stat));
  // R9: interrupt follows a set done flag
  a_r9_irq_src: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(done));
endmodule

// File: rtl/lpws_bridge.sv
module lpws_bridge
  import lpws_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_REGS    = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_TICKS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lp_clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_wc
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] IEN_A  = ADDR_W'(NUM_REGS + 1);

  logic tick, busy, apply, collide;
  logic [ADDR_W-1:0] ap_addr;
  logic [DATA_W-1:0] ap_data;
  logic [DATA_W-1:0] stat_word, ien_word, reg_rd;
  logic [DATA_W-1:0] stat_q, ien_q;
  rsel_e sel_now, sel_q;
  logic  sync_req, ien_we, stat_rd, ap_is_stat, ap_is_data;

  always_comb begin
    if (addr < STAT_A)       sel_now = SEL_DATA;
    else if (addr == STAT_A) sel_now = SEL_STAT;
    else if (addr == IEN_A)  sel_now = SEL_IEN;
    else                     sel_now = SEL_NONE;
  end

  assign sync_req   = wr_en && (sel_now == SEL_DATA || sel_now == SEL_STAT);
  assign ien_we     = wr_en && (sel_now == SEL_IEN);
  assign stat_rd    = rd_en && (sel_now == SEL_STAT);
  assign ap_is_stat = (ap_addr == STAT_A);
  assign ap_is_data = (ap_addr < STAT_A);

  lpws_tick #(.STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .lp_clk(lp_clk), .tick(tick)
  );

  lpws_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TICKS(SYNC_TICKS)) u_engine (
    .clk(clk), .rst(rst), .tick(tick),
    .req(sync_req), .req_addr(addr), .req_data(wdata),
    .busy(busy), .apply(apply), .collide(collide),
    .ap_addr(ap_addr), .ap_data(ap_data)
  );

  lpws_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk),
    .we(apply && ap_is_data), .waddr(ap_addr[IDX_W-1:0]), .wdata(ap_data),
    .re(rd_en), .raddr(addr[IDX_W-1:0]), .rdata(reg_rd)
  );

  lpws_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .busy(busy), .apply(apply),
    .ap_is_stat(ap_is_stat), .ap_err_clr(ap_data[ERR_BIT]),
    .collide(collide), .stat_rd(stat_rd),
    .ien_we(ien_we), .ien_wdata(wdata[IEN_HI:IEN_LO]),
    .stat_word(stat_word), .ien_word(ien_word), .irq(irq_wc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SEL_NONE;
      stat_q <= '0;
      ien_q  <= '0;
    end else if (rd_en) begin
      sel_q  <= sel_now;
      stat_q <= stat_word;
      ien_q  <= ien_word;
    end
  end

  always_comb begin
    case (sel_q)
      SEL_DATA: rdata = reg_rd;
      SEL_STAT: rdata = stat_q;
      SEL_IEN:  rdata = ien_q;
      default:  rdata = '0;
    endcase
  end

  // R6: an enable write alone never starts a synchronised write
  a_r6_ien_no_busy: assert property (@(posedge clk) disable iff (rst)
    (ien_we && !busy) |=> !busy);
endmodule

// File: tb/lpws_bridge_test.sv
`timescale 1ns/1ps
module lpws_bridge_test;
  localparam int NREG = 8;
  localparam int TICKS = 4;
  localparam logic [3:0] STAT = 4'd8;
  localparam logic [3:0] IEN  = 4'd9;

  logic clk = 1'b0, rst = 1'b1, lp_clk = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq_wc;

  int checks = 0, errs = 0, lp_edges = 0;
  logic rd_seen = 1'b0;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } item_t;
  item_t sb_q[$];

  lpws_bridge #(.NUM_REGS(NREG), .SYNC_TICKS(TICKS)) uut (
    .clk(clk), .rst(rst), .lp_clk(lp_clk), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_wc(irq_wc)
  );

  always #2.5 clk = ~clk;
  always #40 lp_clk = ~lp_clk;
  always @(posedge lp_clk) lp_edges++;
  always @(posedge clk) rd_seen <= rd_en;

  // monitor: pops expected read results and compares
  always @(negedge clk) begin
    if (rd_seen && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      if (it.mask != 0) begin
        checks++;
        if ((rdata & it.mask) !== (it.exp & it.mask)) begin
          errs++;
          $display("FAIL %s: got %h expected %h (mask %h)", it.tag, rdata, it.exp, it.mask);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input logic [31:0] m,
                          input string tag, output logic [31:0] v);
    item_t it;
    @(negedge clk); rd_en = 1'b1; addr = a;
    it.exp = e; it.mask = m; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); rd_en = 1'b0;
    v = rdata;
  endtask

  // aligned write: issued a few bus cycles after a slow rising edge
  task automatic sync_write(input logic [3:0] a, input logic [31:0] d, output int e0);
    @(posedge lp_clk);
    repeat (4) @(posedge clk);
    e0 = lp_edges;
    bus_write(a, d);
  endtask

  task automatic wait_edges(input int e0, input int n);
    while (lp_edges < e0 + n) @(posedge clk);
    repeat (6) @(posedge clk);
  endtask

  task automatic wait_idle(output logic [31:0] st);
    st = 32'h400;
    for (int i = 0; i < 400 && st[10]; i++)
      bus_read(STAT, 0, 0, "poll", st);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, st;
    int e0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check(irq_wc == 1'b0, "R1 irq after reset", {31'b0, irq_wc}, 0);
    bus_read(STAT, 32'h200, 32'hFFFF_FFFF, "R1 status after reset", v);
    bus_read(IEN, 32'h0, 32'hFFFF_FFFF, "R1 enable after reset", v);

    // R2/R3/R4/R5 basic write to data reg 3
    sync_write(4'd3, 32'hA5A5_0001, e0);
    bus_read(STAT, 32'h400, 32'h600, "R2 busy set and ready cleared", v);
    while (lp_edges < e0 + 3) @(posedge clk);
    repeat (4) @(posedge clk);
    bus_read(STAT, 32'h400, 32'h400, "R3 still busy after SYNC_TICKS-1 edges", v);
    wait_edges(e0, TICKS);
    check(irq_wc == 1'b0, "R9 no irq with enable clear", {31'b0, irq_wc}, 0);
    wait_idle(st);
    check(lp_edges - e0 == TICKS, "R3 slow edges to completion", lp_edges - e0, TICKS);
    check(st[10:8] == 3'b011, "R4 busy clear ready and done set", {29'b0, st[10:8]}, 3);
    bus_read(STAT, 32'h0, 32'h100, "R5 done cleared by read", v);
    bus_read(4'd3, 32'hA5A5_0001, 32'hFFFF_FFFF, "R3 new value after apply", v);

    // R3 old value held while busy; R9 irq with enable
    bus_write(IEN, 32'h100);
    sync_write(4'd3, 32'h0BAD_F00D, e0);
    bus_read(4'd3, 32'hA5A5_0001, 32'hFFFF_FFFF, "R3 old value while busy", v);
    wait_edges(e0, TICKS);
    check(irq_wc == 1'b1, "R9 irq with done and enable", {31'b0, irq_wc}, 1);
    bus_read(STAT, 32'h100, 32'h100, "R5 read returns done", v);
    repeat (2) @(posedge clk);
    check(irq_wc == 1'b0, "R9 irq drops after status read", {31'b0, irq_wc}, 0);
    bus_read(4'd3, 32'h0BAD_F00D, 32'hFFFF_FFFF, "R3 second value", v);

    // R6 enable write during a pending write
    bus_write(IEN, 32'h0);
    sync_write(4'd5, 32'h1234_5678, e0);
    bus_write(IEN, 32'h380);
    bus_read(IEN, 32'h380, 32'hFFFF_FFFF, "R6 enable readback", v);
    bus_read(STAT, 32'h400, 32'h580, "R6 no error no done while busy", v);
    wait_edges(e0, TICKS);
    wait_idle(st);
    check(lp_edges - e0 == TICKS, "R6 pending write timing unchanged", lp_edges - e0, TICKS);
    bus_read(4'd5, 32'h1234_5678, 32'hFFFF_FFFF, "R6 pending write intact", v);

    // R7 collision
    sync_write(4'd1, 32'hC0C0_C0C0, e0);
    bus_write(4'd1, 32'hDEAD_DEAD);
    bus_read(STAT, 32'h480, 32'h480, "R7 error set while busy", v);
    wait_idle(st);
    check(st[7] == 1'b1, "R7 error held after completion", {31'b0, st[7]}, 1);
    bus_read(4'd1, 32'hC0C0_C0C0, 32'hFFFF_FFFF, "R7 second write discarded", v);

    // R10 status write without clear bit
    sync_write(STAT, 32'h0, e0);
    wait_idle(st);
    check(st[8:7] == 2'b11, "R10 done set and error kept", {30'b0, st[8:7]}, 3);

    // R8 synchronised error clear
    sync_write(STAT, 32'h80, e0);
    bus_read(STAT, 32'h480, 32'h480, "R8 error still set while clear pending", v);
    wait_idle(st);
    check(st[8:7] == 2'b10, "R8 error cleared at completion", {30'b0, st[8:7]}, 2);

    // R9 clearing the enable drops the irq
    bus_write(IEN, 32'h100);
    sync_write(4'd2, 32'h0000_0022, e0);
    wait_edges(e0, TICKS);
    check(irq_wc == 1'b1, "R9 irq raised", {31'b0, irq_wc}, 1);
    bus_write(IEN, 32'h0);
    repeat (2) @(posedge clk);
    check(irq_wc == 1'b0, "R9 irq drops with enable", {31'b0, irq_wc}, 0);
    bus_read(STAT, 32'h100, 32'h100, "R9 done kept after enable clear", v);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule